// File: doc/BRIEF.md
# Periodic Refresh Strobe Scheduler

This block keeps every row of an asynchronous DRAM alive by launching refresh cycles at a fixed pace. In each cycle the column strobe is pulled low first and the row strobe follows it. The memory then takes the row from its own internal counter, so the scheduler has no address port. It has no data, write-enable or output-enable port either, because a refresh cycle moves no data.

The refresh pace comes from the retention requirement of the selected density:

| Row-address width | Rows | Retention window |
|---|---|---|
| 11 bits | 2048 | 32 ms |
| 12 bits | 4096 | 64 ms |

The interval in clocks is the retention window times the clock rate, divided by the row count. This gives about 15.6 µs between refreshes for either density.

A free-running timer adds one to a small backlog each time the interval expires. The block shares the DRAM strobes with an access controller. While refresh work is owed it raises a request, and it starts a cycle only after the grant. It keeps the request high for the whole cycle, including the closing precharge, so the arbiter does not hand the strobes back too early. A count of finished cycles is provided, so a checker can confirm that enough rows were refreshed in each window.

Top module: `refresh_scheduler`

## Requirements
- R1: The backlog grows by one every INTERVAL clocks. INTERVAL = RETENTION_US*CLK_MHZ/2^ROW_BITS, where RETENTION_US is 32000 for ROW_BITS=11 and 64000 for ROW_BITS=12. The first increase is seen INTERVAL clocks after reset is released. Grant timing never shifts this cadence.
- R2: `req_o` is high whenever the backlog is non-zero or a cycle is in progress. It is low otherwise. No strobe falls before a clock edge at which `gnt_i` was high.
- R3: After a grant, the column strobe falls at the next edge. The row strobe falls T_SETUP clocks later, with T_SETUP of at least 1.
- R4: The row strobe stays low for exactly T_RAS clocks. Both strobes then rise on the same edge.
- R5: Once released, both strobes stay high for at least max(T_RP, T_CP) clocks. With a grant held high, the next column fall comes exactly max(T_RP, T_CP)+1 clocks after the release.
- R6: `done_cnt_o` increases by exactly one on the edge where the strobes return high, and at no other time.
- R7: Each grant takes one unit from the backlog. The backlog never exceeds PEND_MAX. A timer expiry on the same edge as a grant leaves the backlog unchanged.
- R8: A timer expiry while the backlog is at PEND_MAX sets `overflow_o` and leaves the backlog at PEND_MAX. The flag then stays set until reset.
- R9: While reset is low, both strobes are high, `req_o` is low, and the backlog, `overflow_o` and `done_cnt_o` are zero.
- R10: A grant has no effect while the backlog is zero and no cycle is in progress: both strobes stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gnt_i | input | 1 | Strobe ownership granted by the arbiter |
| req_o | output | 1 | Request for strobe ownership |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| pending_o | output | $clog2(PEND_MAX+1) | Refresh backlog |
| overflow_o | output | 1 | Sticky flag: backlog limit exceeded |
| done_cnt_o | output | CNT_W | Finished refresh cycles, wrapping |

## Verification
The assertions assume that the arbiter keeps to the handshake. It grants only while a request is high, and it may drop the grant at any time once a cycle has begun, since the block no longer looks at it. The stimulus respects this. It raises the grant for one clock at chosen moments, holds it high only to measure back-to-back precharge, and drives it while the request is low only to check that such a grant is ignored. The bench follows the timer phase with its own count of clocks since reset. This lets it place a grant exactly on an expiry edge and hold off grants until the backlog reaches its limit.

// File: rtl/refresh_pkg.sv
`timescale 1ns/1ps
package refresh_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_PRECH  = 2'd3
    } seq_state_e;

    // Retention window in microseconds for a given row-address width
    function automatic int retention_us(input int row_bits);
        return (row_bits >= 12) ? 64000 : 32000;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_timer.sv
`timescale 1ns/1ps
module rfsh_timer #(
    parameter int INTERVAL = 3125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } timer_regs_t;

    timer_regs_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        tick_o = (tmr_q.cnt == CW'(INTERVAL - 1));
        if (tick_o) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/rfsh_backlog.sv
`timescale 1ns/1ps
module rfsh_backlog #(
    parameter int PEND_MAX = 4,
    localparam int PW = $clog2(PEND_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          take_i,
    output logic [PW-1:0] pending_o,
    output logic          overflow_o
);
    typedef struct packed {
        logic [PW-1:0] cnt;
        logic          ovf;
    } backlog_regs_t;

    backlog_regs_t blg_d, blg_q;
    logic          full;

    always_comb begin
        blg_d = blg_q;
        full  = (blg_q.cnt == PW'(PEND_MAX));
        if (tick_i && !take_i) begin
            if (full) begin
                blg_d.ovf = 1'b1;
            end else begin
                blg_d.cnt = blg_q.cnt + 1'b1;
            end
        end else if (take_i && !tick_i) begin
            if (blg_q.cnt != '0) begin
                blg_d.cnt = blg_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blg_q <= '0;
        end else begin
            blg_q <= blg_d;
        end
    end

    assign pending_o  = blg_q.cnt;
    assign overflow_o = blg_q.ovf;
endmodule

// File: rtl/rfsh_sequencer.sv
`timescale 1ns/1ps
module rfsh_sequencer
    import refresh_pkg::*;
#(
    parameter int T_SETUP = 1,
    parameter int T_RAS   = 12,
    parameter int T_PRECH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic owed_i,
    input  logic gnt_i,
    output logic req_o,
    output logic take_o,
    output logic done_o,
    output logic ras_n_o,
    output logic cas_n_o
);
    localparam int TMAX = max2(max2(T_SETUP, T_RAS), T_PRECH);
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        seq_state_e    st;
        logic [TW-1:0] cnt;
        logic          ras_n;
        logic          cas_n;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        take_o = 1'b0;
        done_o = 1'b0;
        req_o  = (seq_q.st != ST_IDLE) || owed_i;
        case (seq_q.st)
            ST_IDLE: begin
                if (owed_i && gnt_i) begin
                    seq_d.st    = ST_SETUP;
                    seq_d.cnt   = TW'(T_SETUP - 1);
                    seq_d.cas_n = 1'b0;
                    take_o      = 1'b1;
                end
            end
            ST_SETUP: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st    = ST_ACTIVE;
                    seq_d.cnt   = TW'(T_RAS - 1);
                    seq_d.ras_n = 1'b0;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st    = ST_PRECH;
                    seq_d.cnt   = TW'(T_PRECH - 1);
                    seq_d.ras_n = 1'b1;
                    seq_d.cas_n = 1'b1;
                    done_o      = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = ST_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st    <= ST_IDLE;
            seq_q.cnt   <= '0;
            seq_q.ras_n <= 1'b1;
            seq_q.cas_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign ras_n_o = seq_q.ras_n;
    assign cas_n_o = seq_q.cas_n;
endmodule

// File: rtl/rfsh_tally.sv
`timescale 1ns/1ps
module rfsh_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             done_i,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tally_regs_t;

    tally_regs_t tly_d, tly_q;

    always_comb begin
        tly_d = tly_q;
        if (done_i) begin
            tly_d.cnt = tly_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tly_q <= '0;
        end else begin
            tly_q <= tly_d;
        end
    end

    assign count_o = tly_q.cnt;
endmodule

// File: rtl/refresh_scheduler.sv
`timescale 1ns/1ps
module refresh_scheduler
    import refresh_pkg::*;
#(
    parameter int ROW_BITS = 11,
    parameter int CLK_MHZ  = 200,
    parameter int T_SETUP  = 1,
    parameter int T_RAS    = 12,
    parameter int T_RP     = 8,
    parameter int T_CP     = 2,
    parameter int PEND_MAX = 4,
    parameter int CNT_W    = 16,
    localparam int PW      = $clog2(PEND_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gnt_i,
    output logic             req_o,
    output logic             ras_n_o,
    output logic             cas_n_o,
    output logic [PW-1:0]    pending_o,
    output logic             overflow_o,
    output logic [CNT_W-1:0] done_cnt_o
);
    localparam int ROWS     = 1 << ROW_BITS;
    localparam int INTERVAL = retention_us(ROW_BITS) * CLK_MHZ / ROWS;
    localparam int T_PRECH  = max2(T_RP, T_CP);
    localparam int SETUP_EFF = max2(T_SETUP, 1);

    logic tick;
    logic take;
    logic done;
    logic owed;

    rfsh_timer #(
        .INTERVAL (INTERVAL)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rfsh_backlog #(
        .PEND_MAX (PEND_MAX)
    ) i_backlog (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .take_i     (take),
        .pending_o  (pending_o),
        .overflow_o (overflow_o)
    );

    assign owed = (pending_o != '0);

    rfsh_sequencer #(
        .T_SETUP (SETUP_EFF),
        .T_RAS   (T_RAS),
        .T_PRECH (T_PRECH)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .owed_i  (owed),
        .gnt_i   (gnt_i),
        .req_o   (req_o),
        .take_o  (take),
        .done_o  (done),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o)
    );

    rfsh_tally #(
        .CNT_W (CNT_W)
    ) i_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (done),
        .count_o (done_cnt_o)
    );
endmodule

// File: rtl/refresh_scheduler_chk.sv
`timescale 1ns/1ps
module refresh_scheduler_chk #(
    parameter int T_SETUP  = 1,
    parameter int T_RAS    = 12,
    parameter int T_PRECH  = 8,
    parameter int PEND_MAX = 4,
    parameter int PW       = 3,
    parameter int CNT_W    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gnt_i,
    input logic             req_o,
    input logic             ras_n_o,
    input logic             cas_n_o,
    input logic [PW-1:0]    pending_o,
    input logic             overflow_o,
    input logic [CNT_W-1:0] done_cnt_o
);
    logic [15:0] ras_lo_q;
    logic [15:0] cas_lo_q;
    logic [15:0] cas_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_lo_q <= '0;
            cas_lo_q <= '0;
            cas_hi_q <= 16'hFFFF;
        end else begin
            ras_lo_q <= ras_n_o ? 16'd0 : ((ras_lo_q == 16'hFFFF) ? ras_lo_q : ras_lo_q + 16'd1);
            cas_lo_q <= cas_n_o ? 16'd0 : ((cas_lo_q == 16'hFFFF) ? cas_lo_q : cas_lo_q + 16'd1);
            cas_hi_q <= !cas_n_o ? 16'd0 : ((cas_hi_q == 16'hFFFF) ? cas_hi_q : cas_hi_q + 16'd1);
        end
    end

    // R3
    ras_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> (!cas_n_o && cas_lo_q >= 16'(T_SETUP)));

    // R4
    ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> (ras_lo_q == 16'(T_RAS)));

    // R4
    release_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n_o) |-> $rose(ras_n_o));

    // R5
    precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n_o) |-> (cas_hi_q >= 16'(T_PRECH)));

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !gnt_i && pending_o != '0) |=> req_o);

    // R2
    strobe_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n_o |-> req_o);

    // R2
    start_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n_o) |-> $past(gnt_i));

    // R6
    done_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_cnt_o != $past(done_cnt_o)) |->
            ($rose(ras_n_o) && done_cnt_o == CNT_W'($past(done_cnt_o) + 1'b1)));

    // R7
    pending_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending_o <= PW'(PEND_MAX));

    // R8
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    // R8
    overflow_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_o) |-> (pending_o == PW'(PEND_MAX)));
endmodule

bind refresh_scheduler refresh_scheduler_chk #(
    .T_SETUP  (SETUP_EFF),
    .T_RAS    (T_RAS),
    .T_PRECH  (T_PRECH),
    .PEND_MAX (PEND_MAX),
    .PW       (PW),
    .CNT_W    (CNT_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gnt_i      (gnt_i),
    .req_o      (req_o),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .pending_o  (pending_o),
    .overflow_o (overflow_o),
    .done_cnt_o (done_cnt_o)
);

// File: tb/test_refresh_scheduler.sv
`timescale 1ns/1ps
module test_refresh_scheduler;
    // Bench scaling: 4 "MHz" worth of timer ticks keeps the run short
    localparam int CLK_MHZ  = 4;
    localparam int INTERVAL = 32000 * CLK_MHZ / 2048;   // 62 clocks
    localparam int T_RAS    = 12;
    localparam int T_PRECH  = 8;
    localparam int PEND_MAX = 4;
    localparam int PW       = 3;

    // delay before grant, expected setup clocks, expected row-low clocks
    localparam int VEC [4][3] = '{
        '{0,  1, 12},
        '{3,  1, 12},
        '{7,  1, 12},
        '{20, 1, 12}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gnt_i = 1'b0;
    logic          req_o, ras_n_o, cas_n_o, overflow_o;
    logic [PW-1:0] pending_o;
    logic [15:0]   done_cnt_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    refresh_scheduler #(
        .ROW_BITS (11),
        .CLK_MHZ  (CLK_MHZ),
        .T_SETUP  (1),
        .T_RAS    (T_RAS),
        .T_RP     (T_PRECH),
        .T_CP     (2),
        .PEND_MAX (PEND_MAX),
        .CNT_W    (16)
    ) i_refresh_scheduler (
        .clk        (clk),
        .rst_n      (rst_n),
        .gnt_i      (gnt_i),
        .req_o      (req_o),
        .ras_n_o    (ras_n_o),
        .cas_n_o    (cas_n_o),
        .pending_o  (pending_o),
        .overflow_o (overflow_o),
        .done_cnt_o (done_cnt_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reset_state(input string tag);
        chk(ras_n_o == 1'b1 && cas_n_o == 1'b1, tag, {ras_n_o, cas_n_o}, 3);
        chk(req_o == 1'b0, tag, req_o, 0);
        chk(pending_o == 0 && overflow_o == 1'b0, tag, {pending_o, overflow_o}, 0);
        chk(done_cnt_o == 0, tag, done_cnt_o, 0);
    endtask

    initial begin
        #(20000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        int done0;
        int p;
        bit seen;

        // R9: reset state
        repeat (4) @(negedge clk);
        reset_state("R9 reset");
        rst_n = 1'b1;

        // R1 / R10 / R2: grant held high with nothing owed has no effect
        gnt_i = 1'b1;
        n = 0;
        seen = 1'b0;
        while (pending_o == 0 && n < 500) begin
            @(negedge clk);
            n++;
            if (pending_o == 0 && (cas_n_o == 1'b0 || req_o == 1'b1)) seen = 1'b1;
        end
        gnt_i = 1'b0;
        chk(!seen, "R10 grant ignored when idle", seen, 0);
        chk(n == INTERVAL, "R1 first expiry", n, INTERVAL);
        chk(req_o == 1'b1, "R2 request with backlog", req_o, 1);

        // Vector loop: grant after varying delays
        for (int v = 0; v < 4; v++) begin
            n = 0;
            while (!req_o && n < 500) begin
                @(negedge clk);
                n++;
            end
            seen = 1'b0;
            for (int d = 0; d < VEC[v][0]; d++) begin
                @(negedge clk);
                if (cas_n_o == 1'b0 || req_o == 1'b0) seen = 1'b1;
            end
            chk(!seen, "R2 no strobe before grant", seen, 0);
            done0 = done_cnt_o;
            gnt_i = 1'b1;
            @(negedge clk);
            gnt_i = 1'b0;
            chk(cas_n_o == 1'b0 && ras_n_o == 1'b1, "R3 column strobe first",
                {cas_n_o, ras_n_o}, 1);
            n = 0;
            while (ras_n_o == 1'b1 && n < 50) begin
                n++;
                @(negedge clk);
            end
            chk(n == VEC[v][1], "R3 setup clocks", n, VEC[v][1]);
            n = 0;
            while (ras_n_o == 1'b0 && n < 50) begin
                n++;
                @(negedge clk);
            end
            chk(n == VEC[v][2], "R4 row strobe width", n, VEC[v][2]);
            chk(cas_n_o == 1'b1, "R4 both strobes released", cas_n_o, 1);
            chk(done_cnt_o == 16'(done0 + 1), "R6 completed count", done_cnt_o, done0 + 1);
            repeat (T_PRECH) @(negedge clk);
        end

        // R7: grant on the same edge as a timer expiry
        n = 0;
        while (!((cyc % INTERVAL) == INTERVAL - 1 && pending_o != 0) && n < 1000) begin
            @(negedge clk);
            n++;
        end
        p = pending_o;
        gnt_i = 1'b1;
        @(negedge clk);
        gnt_i = 1'b0;
        chk(pending_o == p, "R7 expiry and grant together", pending_o, p);
        chk(cas_n_o == 1'b0, "R7 cycle started", cas_n_o, 0);
        n = 0;
        while (ras_n_o == 1'b1 && n < 50) begin @(negedge clk); n++; end
        while (ras_n_o == 1'b0 && n < 100) begin @(negedge clk); n++; end
        repeat (T_PRECH) @(negedge clk);

        // R8: backlog fills, then one more expiry sets the flag
        n = 0;
        while (!((cyc % INTERVAL) == 0 && pending_o == PEND_MAX) && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(pending_o == PEND_MAX, "R7 backlog reaches limit", pending_o, PEND_MAX);
        chk(overflow_o == 1'b0, "R8 no flag at limit", overflow_o, 0);
        repeat (INTERVAL - 1) @(negedge clk);
        chk(overflow_o == 1'b0, "R1 no early expiry", overflow_o, 0);
        @(negedge clk);
        chk(overflow_o == 1'b1, "R8 flag on excess expiry", overflow_o, 1);
        chk(pending_o == PEND_MAX, "R8 backlog held at limit", pending_o, PEND_MAX);

        // R7: grant removes one unit
        gnt_i = 1'b1;
        @(negedge clk);
        gnt_i = 1'b0;
        chk(pending_o == PEND_MAX - 1, "R7 grant takes one", pending_o, PEND_MAX - 1);
        chk(overflow_o == 1'b1, "R8 flag sticky", overflow_o, 1);

        // R5: back-to-back cycles with grant held high
        n = 0;
        while (ras_n_o == 1'b1 && n < 50) begin @(negedge clk); n++; end
        while (ras_n_o == 1'b0 && n < 100) begin @(negedge clk); n++; end
        gnt_i = 1'b1;
        n = 0;
        while (cas_n_o == 1'b1 && n < 50) begin
            n++;
            @(negedge clk);
        end
        gnt_i = 1'b0;
        chk(n == T_PRECH + 1, "R5 precharge gap", n, T_PRECH + 1);

        // R9: reset during operation
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        reset_state("R9 mid-run reset");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule